// File: doc/BRIEF.md
# Packed halfword add-subtract unit

This block is the execution slice for signed dual-halfword arithmetic. Each 32-bit operand is seen as two signed 16-bit lanes. A two-bit operation code picks one of four lane operations: add both lanes, subtract both lanes, or one of two exchange forms. In an exchange form each lane of the first operand is combined with the opposite lane of the second operand, and one lane adds while the other subtracts. The two lane results are packed into one 32-bit result. Each lane also produces a pair of greater-or-equal flags, taken from the sign of its exact, unwrapped result.

The unit receives a 32-bit instruction word together with the two operand values that the surrounding pipeline has already read. It pulls the register indices and the operation selector out of the word. It presents the two source indices combinationally, so they can address a register file. The destination index, the result and the flags are registered one clock after the instruction is accepted. A condition field that reads "always" executes unconditionally. Any other condition needs an external condition-pass input. A skipped instruction leaves the result and the flags untouched.

Top module: `phw_addsub`

## Requirements
- R1: The low lane of an operand is bits 15:0 and the high lane is bits 31:16. Both lanes are signed. The low-lane result goes to result bits 15:0 and the high-lane result to bits 31:16, each truncated to 16 bits.
- R2: Selector value 0 gives low = Nlo + Mlo and high = Nhi + Mhi.
- R3: Selector value 1 gives low = Nlo - Mhi and high = Nhi + Mlo.
- R4: Selector value 2 gives low = Nlo + Mhi and high = Nhi - Mlo.
- R5: Selector value 3 gives low = Nlo - Mlo and high = Nhi - Mhi.
- R6: Flag bits 1:0 are both 1 when the exact low-lane result is zero or positive, and both 0 otherwise. Flag bits 3:2 follow the high lane in the same way. This holds even when the packed 16-bit value shows the opposite sign, for example 0x7FFF + 1.
- R7: In the instruction word, bits 3:0 hold the second source index and bits 19:16 the first source index. Both appear on the source index outputs in the same cycle. Bits 15:12 hold the destination index, which is registered with the result. Bits 7:5 hold the operation selector.
- R8: Condition field bits 31:28 equal to 0xE always execute. Any other value executes only when cond_pass is 1.
- R9: An accepted instruction that does not execute drives res_valid and flag_we low on the next cycle. The result, the flags and the destination index keep their previous values.
- R10: A selector value of 4 to 7 (bit 7 set) that executes produces a zero result and flags 4'b1111.
- R11: After reset, result, flags, destination index, res_valid and flag_we are all zero.
- R12: Results appear on the clock edge after instr_valid is sampled high. flag_we always equals res_valid. With instr_valid low, both are low on the next cycle and the stored state is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction word and operands are present this cycle |
| instr | input | 32 | Instruction word |
| cond_pass | input | 1 | External condition evaluation passed |
| opnd_n | input | 32 | First operand value |
| opnd_m | input | 32 | Second operand value |
| src_n_idx | output | 4 | First source register index (combinational) |
| src_m_idx | output | 4 | Second source register index (combinational) |
| dst_idx | output | 4 | Registered destination index |
| result | output | 32 | Registered packed result |
| res_valid | output | 1 | Result written this cycle |
| flag_we | output | 1 | Flag write enable |
| ge_flags | output | 4 | Registered greater-or-equal flags |

## Verification
The bench builds the unit with its defaults: 16-bit lanes and two flag bits per lane. With these widths the field positions in the instruction word line up, and the lane extremes 0x7FFF and 0x8000 can be driven directly. That makes every case of an exact result leaving the 16-bit range reachable, both positive overflow and negative underflow, so a flag derived from the truncated value can be told apart from one derived from the true sign. Directed words cover each selector, the out-of-range selectors, an always-condition against a failing cond_pass, and idle cycles. A long pseudo-random run then mixes all of these.

// File: rtl/phw_pkg.sv
package phw_pkg;
  localparam logic [3:0] COND_ALWAYS = 4'hE;

  typedef enum logic [1:0] {
    OP_ADD2 = 2'd0,
    OP_AXS  = 2'd1,
    OP_SXA  = 2'd2,
    OP_SUB2 = 2'd3
  } lane_op_e;

  typedef struct packed {
    logic [3:0] cond;
    logic [3:0] rn;
    logic [3:0] rd;
    logic [3:0] rm;
    logic [2:0] sel;
  } ifield_t;
endpackage

// File: rtl/phw_decode.sv
module phw_decode
  import phw_pkg::*;
(
  input  logic [31:0] instr,
  input  logic        instr_valid,
  input  logic        cond_pass,
  output ifield_t     fld,
  output lane_op_e    op,
  output logic        sel_bad,
  output logic        exec
);
  always_comb begin
    fld.cond = instr[31:28];
    fld.rn   = instr[19:16];
    fld.rd   = instr[15:12];
    fld.rm   = instr[3:0];
    fld.sel  = instr[7:5];
  end

  assign op      = lane_op_e'(fld.sel[1:0]);
  assign sel_bad = fld.sel[2];
  assign exec    = instr_valid && ((fld.cond == COND_ALWAYS) || cond_pass);
endmodule

// File: rtl/phw_lane.sv
module phw_lane #(
  parameter int unsigned LANE_W = 16
) (
  input  logic [LANE_W-1:0] a,
  input  logic [LANE_W-1:0] b,
  input  logic              sub,
  output logic [LANE_W-1:0] res,
  output logic              ge
);
  logic signed [LANE_W:0] ax;
  logic signed [LANE_W:0] bx;
  logic signed [LANE_W:0] sum;

  always_comb begin
    ax  = {a[LANE_W-1], a};
    bx  = {b[LANE_W-1], b};
    sum = sub ? (ax - bx) : (ax + bx);
  end

  assign res = sum[LANE_W-1:0];
  assign ge  = ~sum[LANE_W];
endmodule

// File: rtl/phw_addsub.sv
module phw_addsub
  import phw_pkg::*;
#(
  parameter int unsigned LANE_W      = 16,
  parameter int unsigned GE_PER_LANE = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      instr_valid,
  input  logic [31:0]               instr,
  input  logic                      cond_pass,
  input  logic [2*LANE_W-1:0]       opnd_n,
  input  logic [2*LANE_W-1:0]       opnd_m,
  output logic [3:0]                src_n_idx,
  output logic [3:0]                src_m_idx,
  output logic [3:0]                dst_idx,
  output logic [2*LANE_W-1:0]       result,
  output logic                      res_valid,
  output logic                      flag_we,
  output logic [2*GE_PER_LANE-1:0]  ge_flags
);
  localparam int unsigned NLANES = 2;
  localparam int unsigned DATA_W = NLANES * LANE_W;
  localparam int unsigned FLAG_W = NLANES * GE_PER_LANE;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  // field decode
  ifield_t  fld;
  lane_op_e op;
  logic     sel_bad;
  logic     exec;

  phw_decode u_dec (
    .instr       (instr),
    .instr_valid (instr_valid),
    .cond_pass   (cond_pass),
    .fld         (fld),
    .op          (op),
    .sel_bad     (sel_bad),
    .exec        (exec)
  );

  assign src_n_idx = fld.rn;
  assign src_m_idx = fld.rm;

  // lane datapath
  logic              exch;
  logic [DATA_W-1:0] packed_res;
  logic [FLAG_W-1:0] packed_ge;

  assign exch = op[0] ^ op[1];

  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    logic [LANE_W-1:0] a_l;
    logic [LANE_W-1:0] b_l;
    logic [LANE_W-1:0] r_l;
    logic              ge_l;

    assign a_l = opnd_n[g*LANE_W +: LANE_W];
    assign b_l = exch ? opnd_m[(NLANES-1-g)*LANE_W +: LANE_W]
                      : opnd_m[g*LANE_W +: LANE_W];

    phw_lane #(.LANE_W(LANE_W)) u_lane (
      .a   (a_l),
      .b   (b_l),
      .sub (op[g]),
      .res (r_l),
      .ge  (ge_l)
    );

    assign packed_res[g*LANE_W +: LANE_W]           = r_l;
    assign packed_ge[g*GE_PER_LANE +: GE_PER_LANE]  = {GE_PER_LANE{ge_l}};
  end

  // next state
  logic [DATA_W-1:0] result_d, result_q;
  logic [FLAG_W-1:0] flags_d, flags_q;
  logic [3:0]        dst_d, dst_q;
  logic              valid_d, valid_q;

  always_comb begin
    valid_d = exec;
    dst_d   = fld.rd;
    if (sel_bad) begin
      result_d = '0;
      flags_d  = '1;
    end else begin
      result_d = packed_res;
      flags_d  = packed_ge;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      valid_q  <= 1'b0;
      result_q <= '0;
      flags_q  <= '0;
      dst_q    <= '0;
    end else begin
      valid_q <= valid_d;
      if (exec) begin
        result_q <= result_d;
        flags_q  <= flags_d;
        dst_q    <= dst_d;
      end
    end
  end

  assign result    = result_q;
  assign ge_flags  = flags_q;
  assign dst_idx   = dst_q;
  assign res_valid = valid_q;
  assign flag_we   = valid_q;
endmodule

// File: rtl/phw_addsub_chk.sv
module phw_addsub_chk #(
  parameter int unsigned LANE_W      = 16,
  parameter int unsigned GE_PER_LANE = 2
) (
  input logic                     clk,
  input logic                     rst_q_n,
  input logic                     instr_valid,
  input logic [31:0]              instr,
  input logic                     cond_pass,
  input logic [2*LANE_W-1:0]      opnd_n,
  input logic [2*LANE_W-1:0]      opnd_m,
  input logic [3:0]               dst_idx,
  input logic [2*LANE_W-1:0]      result,
  input logic                     res_valid,
  input logic                     flag_we,
  input logic [2*GE_PER_LANE-1:0] ge_flags
);
  localparam int unsigned FLAG_W = 2 * GE_PER_LANE;

  logic will_run;
  logic [LANE_W-1:0] lo_sum;
  assign will_run = instr_valid && ((instr[31:28] == 4'hE) || cond_pass);
  assign lo_sum   = opnd_n[LANE_W-1:0] + opnd_m[LANE_W-1:0];

  assert_flag_pairs_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    ge_flags == {{GE_PER_LANE{ge_flags[FLAG_W-1]}}, {GE_PER_LANE{ge_flags[0]}}});

  assert_run_valid_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    will_run |=> res_valid);

  assert_skip_hold_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    !will_run |=> (!res_valid && $stable(result) && $stable(ge_flags) && $stable(dst_idx)));

  assert_oor_zero_R10: assert property (@(posedge clk) disable iff (!rst_q_n)
    (will_run && instr[7]) |=> (result == '0 && (&ge_flags)));

  assert_dst_idx_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    will_run |=> (dst_idx == $past(instr[15:12])));

  assert_add_low_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (will_run && instr[7:5] == 3'd0) |=> (result[LANE_W-1:0] == $past(lo_sum)));

  assert_we_match_R12: assert property (@(posedge clk) disable iff (!rst_q_n)
    flag_we == res_valid);
endmodule

bind phw_addsub phw_addsub_chk #(.LANE_W(LANE_W), .GE_PER_LANE(GE_PER_LANE)) u_chk (
  .clk         (clk),
  .rst_q_n     (rst_q_n),
  .instr_valid (instr_valid),
  .instr       (instr),
  .cond_pass   (cond_pass),
  .opnd_n      (opnd_n),
  .opnd_m      (opnd_m),
  .dst_idx     (dst_idx),
  .result      (result),
  .res_valid   (res_valid),
  .flag_we     (flag_we),
  .ge_flags    (ge_flags)
);

// File: tb/phw_addsub_tb.sv
module phw_addsub_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        instr_valid;
  logic [31:0] instr;
  logic        cond_pass;
  logic [31:0] opnd_n, opnd_m;
  logic [3:0]  src_n_idx, src_m_idx, dst_idx;
  logic [31:0] result;
  logic        res_valid, flag_we;
  logic [3:0]  ge_flags;

  always #5 clk = ~clk;

  phw_addsub u_dut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
    .cond_pass(cond_pass), .opnd_n(opnd_n), .opnd_m(opnd_m),
    .src_n_idx(src_n_idx), .src_m_idx(src_m_idx), .dst_idx(dst_idx),
    .result(result), .res_valid(res_valid), .flag_we(flag_we), .ge_flags(ge_flags)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  string tag   = "R11";
  logic [31:0] e_res = '0;
  logic [3:0]  e_flg = '0;
  logic [3:0]  e_dst = '0;
  logic        e_val = 1'b0;

  task automatic cmp(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_outs();
    cmp("result",    result,          e_res);
    cmp("ge_flags",  {28'd0, ge_flags}, {28'd0, e_flg});
    cmp("dst_idx",   {28'd0, dst_idx},  {28'd0, e_dst});
    cmp("res_valid", {31'd0, res_valid}, {31'd0, e_val});
    cmp("flag_we",   {31'd0, flag_we},   {31'd0, e_val});
  endtask

  function automatic int sx16(input logic [15:0] v);
    return int'($signed(v));
  endfunction

  function automatic logic [31:0] mk(input logic [3:0] c, input logic [3:0] rn,
                                     input logic [3:0] rd, input logic [3:0] rm,
                                     input logic [2:0] sel);
    return {c, 8'h61, rn, rd, 4'hF, sel, 1'b1, rm};
  endfunction

  task automatic cyc(input logic v, input logic [31:0] ins, input logic [31:0] a,
                     input logic [31:0] b, input logic p, input string t);
    int lo, hi;
    logic run;
    @(negedge clk);
    check_outs();
    tag = t;
    instr_valid = v; instr = ins; opnd_n = a; opnd_m = b; cond_pass = p;
    #1;
    tag = "R7";
    cmp("src_n_idx", {28'd0, src_n_idx}, {28'd0, ins[19:16]});
    cmp("src_m_idx", {28'd0, src_m_idx}, {28'd0, ins[3:0]});
    tag = t;
    run = v && ((ins[31:28] == 4'hE) || p);
    e_val = run;
    if (run) begin
      lo = 0; hi = 0;
      case (ins[7:5])
        3'd0: begin lo = sx16(a[15:0]) + sx16(b[15:0]);  hi = sx16(a[31:16]) + sx16(b[31:16]); end
        3'd1: begin lo = sx16(a[15:0]) - sx16(b[31:16]); hi = sx16(a[31:16]) + sx16(b[15:0]);  end
        3'd2: begin lo = sx16(a[15:0]) + sx16(b[31:16]); hi = sx16(a[31:16]) - sx16(b[15:0]);  end
        3'd3: begin lo = sx16(a[15:0]) - sx16(b[15:0]);  hi = sx16(a[31:16]) - sx16(b[31:16]); end
        default: begin lo = 0; hi = 0; end
      endcase
      e_res = {hi[15:0], lo[15:0]};
      e_flg = {(hi >= 0) ? 2'b11 : 2'b00, (lo >= 0) ? 2'b11 : 2'b00};
      e_dst = ins[15:12];
    end
  endtask

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; instr_valid = 1'b0; instr = '0; cond_pass = 1'b0;
    opnd_n = '0; opnd_m = '0;
    repeat (3) @(negedge clk);
    check_outs();                       // R11 during reset
    rst_n = 1'b1;
    repeat (3) cyc(1'b0, '0, '0, '0, 1'b0, "R11");
    // R2 with R6 overflow: hi 0x7FFF+1 exact positive, packed 0x8000
    cyc(1'b1, mk(4'hE, 4'h1, 4'h2, 4'h3, 3'd0), 32'h7FFF_0001, 32'h0001_FFFF, 1'b0, "R2");
    cyc(1'b1, mk(4'hE, 4'h4, 4'h5, 4'h6, 3'd1), 32'h0005_0003, 32'h0002_0007, 1'b0, "R3");
    cyc(1'b1, mk(4'hE, 4'h7, 4'h8, 4'h9, 3'd2), 32'h0005_0003, 32'h0009_0007, 1'b0, "R4");
    // R5 with R6 underflow: hi 0x8000-1 exact negative, packed 0x7FFF
    cyc(1'b1, mk(4'hE, 4'hA, 4'hB, 4'hC, 3'd3), 32'h8000_0000, 32'h0001_0001, 1'b0, "R5");
    cyc(1'b1, mk(4'hE, 4'h1, 4'hD, 4'h2, 3'd0), 32'h8000_8000, 32'h8000_8000, 1'b0, "R6");
    cyc(1'b1, mk(4'hE, 4'h3, 4'h1, 4'h4, 3'd1), 32'h1234_5678, 32'h9ABC_DEF0, 1'b0, "R1");
    // R8: non-always condition with pass high executes
    cyc(1'b1, mk(4'h0, 4'h2, 4'h6, 4'h5, 3'd3), 32'h0010_0020, 32'h0030_0001, 1'b1, "R8");
    // R9: non-always condition with pass low holds state
    cyc(1'b1, mk(4'h1, 4'h2, 4'h9, 4'h5, 3'd0), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R9");
    cyc(1'b1, mk(4'hF, 4'h2, 4'hA, 4'h5, 3'd3), 32'h0000_0000, 32'h0001_0001, 1'b0, "R9");
    // R10 out-of-range selectors
    cyc(1'b1, mk(4'hE, 4'h1, 4'h3, 4'h2, 3'd4), 32'h8000_8000, 32'h7FFF_7FFF, 1'b0, "R10");
    cyc(1'b1, mk(4'hE, 4'h1, 4'h4, 4'h2, 3'd7), 32'hFFFF_0000, 32'h0001_0001, 1'b0, "R10");
    cyc(1'b1, mk(4'hE, 4'h1, 4'h7, 4'h2, 3'd3), 32'h0000_0000, 32'h0001_0001, 1'b0, "R6");
    // R12: idle cycle holds state, valid drops
    cyc(1'b0, mk(4'hE, 4'h1, 4'h8, 4'h2, 3'd0), 32'h1111_1111, 32'h2222_2222, 1'b1, "R12");
    cyc(1'b0, '0, '0, '0, 1'b0, "R12");
    for (int i = 0; i < 400; i++) begin
      logic [31:0] w;
      w = $urandom;
      if (w[27]) w[31:28] = 4'hE;
      cyc(w[26], w, $urandom, $urandom, w[25], "R1");
    end
    @(negedge clk);
    check_outs();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule